// File: doc/BRIEF.md
# DMA Interrupt Pending Aggregator

This block collects the interrupt flags of every channel of a small multi-channel DMA controller. The flags are suspend, transfer complete and transfer error. It shows them through a single 16-bit register at byte offset 0x20. A channel engine raises a flag with a one-cycle set pulse. The flag then stays set until software clears it.

With no software involvement, the register names the lowest-numbered channel that has any flag set. It also shows that channel's three flags and three live status levels: pending, busy and descriptor fetch fault. Software works through pending interrupts in channel order. Each write of ones to the flag bits clears them for the indicated channel, and the indicator then moves on to the next pending channel.

Software may also write a channel number into the ID field. The flag bits and status bits then refer to that channel. This selection holds until one of two things happens: a flag is raised on a lower channel, or a clear write leaves the selected channel with no flags. After either event, automatic lowest-pending selection resumes. A combined interrupt output is high while any flag of any channel is set.

Top module: `irq_pend_agg`

## Requirements
- R1: After reset all flags are clear, selection is automatic, `irq_o` is low, and the register reads 0x0000 while channel 0's status inputs are low.
- R2: The register answers only at `addr_i` = 0x20; any other address reads 0. Field positions: bit 15 pending, bit 14 busy, bit 13 fetch fault, bit 10 suspend flag, bit 9 transfer-complete flag, bit 8 transfer-error flag, bits 4:0 channel ID. Bits 12:11 and 7:5 always read 0.
- R3: A set pulse on a channel's suspend, transfer-complete or transfer-error input makes that flag read 1 from the next cycle. A set pulse and a clear of the same flag in the same cycle leave the flag set.
- R4: In automatic selection the ID field reads the lowest channel with any flag set. It reads 0 when no channel has a flag set, and it follows new lower-channel flags in the cycle after they are raised.
- R5: A write at 0x20 with any of bits 10:8 at 1 is a clear write. It clears each flag whose bit is 1, for the channel indicated before the write. Flags whose bit is 0 are unchanged, and the write's bits 4:0 are ignored.
- R6: Bits 15, 14 and 13 show the current levels of `pend_i`, `busy_i` and `ferr_i` for the indicated channel.
- R7: A write at 0x20 with bits 10:8 all 0 is a select write. From the next cycle, bits 15:13 and 10:8 refer to the channel in bits 4:0 of the write. The ID field reads that channel while any flag of any channel is set, and reads 0 otherwise.
- R8: A selection made by a select write ends, and automatic selection resumes, after either of two events: a cycle with a set pulse on a channel numbered below the selected one, or a clear write that leaves the selected channel with no flag set.
- R9: If the selected channel number is `NUM_CH` or above, bits 15:13 and 10:8 read 0 and clear writes change no flag.
- R10: `irq_o` is high exactly when at least one flag of at least one channel is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| susp_set_i | input | NUM_CH | Suspend flag set pulse, one bit per channel |
| tcmpl_set_i | input | NUM_CH | Transfer-complete flag set pulse, one bit per channel |
| terr_set_i | input | NUM_CH | Transfer-error flag set pulse, one bit per channel |
| pend_i | input | NUM_CH | Channel pending status level |
| busy_i | input | NUM_CH | Channel busy status level |
| ferr_i | input | NUM_CH | Channel descriptor fetch fault level |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the cases that an ordering or priority mistake would break:
- **Set against clear.** A set pulse and a clear of the same flag arrive in the same cycle. A design that let the clear win would drop the interrupt.
- **Selection exit.** A select write is followed by a lower-channel event, or by a clear write that drains the selected channel. A design that never left the selection would hide the lower channel. One that left it too early would point the clear bits at the wrong channel.
- **Every ID value.** All 32 ID values are swept on a six-channel build, including the nonexistent ones. A design without a range guard would show or clear the flags of an aliased channel.
- **Random traffic.** Long stretches of random traffic check that clear writes ignore their ID bits and that select writes leave every flag untouched.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int ID_W = 5;
  localparam int REG_W = 16;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] REG_OFF = 8'h20;
  localparam int B_PEND = 15;
  localparam int B_BUSY = 14;
  localparam int B_FERR = 13;
  localparam int B_SUSP = 10;
  localparam int B_TCMPL = 9;
  localparam int B_TERR = 8;
  localparam int KINDS = 3;
  // flag triple ordered {susp, tcmpl, terr} so it lines up with bits 10:8
  typedef logic [KINDS-1:0] kind_vec_t;
endpackage

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int N  = 8,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int c = N - 1; c >= 0; c--) begin
      if (req_i[c]) begin
        idx_o = IW'(c);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ch_mux.sv
module irq_ch_mux #(
  parameter int N  = 8,
  parameter int DW = 3,
  parameter int IW = 5
) (
  input  logic [N-1:0][DW-1:0] data_i,
  input  logic [IW-1:0]        idx_i,
  output logic [DW-1:0]        data_o,
  output logic                 hit_o
);
  // index outside 0..N-1 yields zero data and no hit
  always_comb begin
    data_o = '0;
    hit_o  = 1'b0;
    for (int c = 0; c < N; c++) begin
      if (idx_i == IW'(c)) begin
        data_o = data_i[c];
        hit_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pend_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0][KINDS-1:0] set_i,
  input  logic                     clr_en_i,
  input  logic [ID_W-1:0]          clr_id_i,
  input  kind_vec_t                clr_mask_i,
  output logic [NUM_CH-1:0][KINDS-1:0] flags_o,
  output logic [NUM_CH-1:0][KINDS-1:0] flags_d_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic      clr_hit;
    kind_vec_t flg_q;

    assign clr_hit = clr_en_i && (clr_id_i == ID_W'(c));
    // set wins over a same-cycle clear
    assign flags_d_o[c] = (flg_q & ~(clr_mask_i & {KINDS{clr_hit}})) | set_i[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flg_q <= '0;
      else         flg_q <= flags_d_o[c];
    end

    assign flags_o[c] = flg_q;
  end
endmodule

// File: rtl/irq_id_ctrl.sv
module irq_id_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_wr_i,
  input  logic [ID_W-1:0]   sel_wdata_i,
  input  logic              sel_drain_i,
  input  logic [NUM_CH-1:0] set_any_i,
  input  logic [ID_W-1:0]   low_idx_i,
  input  logic              low_vld_i,
  output logic [ID_W-1:0]   sel_o,
  output logic [ID_W-1:0]   cur_id_o
);
  logic            sw_q;
  logic [ID_W-1:0] sel_q;
  logic [NUM_CH-1:0] below;
  logic            lower_set;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_below
    assign below[c] = set_any_i[c] && (ID_W'(c) < sel_q);
  end
  assign lower_set = |below;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      sel_q <= '0;
    end else if (sel_wr_i) begin
      sw_q  <= 1'b1;
      sel_q <= sel_wdata_i;
    end else if (sw_q && (lower_set || sel_drain_i)) begin
      sw_q <= 1'b0;
    end
  end

  assign sel_o    = sel_q;
  assign cur_id_o = sw_q ? sel_q : (low_vld_i ? low_idx_i : '0);
endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg
  import irq_pend_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] susp_set_i,
  input  logic [NUM_CH-1:0] tcmpl_set_i,
  input  logic [NUM_CH-1:0] terr_set_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] busy_i,
  input  logic [NUM_CH-1:0] ferr_i,
  input  logic [7:0]        addr_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o
);
  localparam int REC_W = 2 * KINDS;

  logic [NUM_CH-1:0][KINDS-1:0] set_vec, flags_q, flags_d;
  logic [NUM_CH-1:0][REC_W-1:0] rec_vec;
  logic [NUM_CH-1:0] ch_any, set_any;
  logic [ID_W-1:0]   low_idx, cur_id, sel_q;
  logic              low_vld, any_pend;
  logic              hit, clr_wr, sel_wr, sel_drain, sel_hit, cur_hit;
  kind_vec_t         w1c, sel_nxt;
  logic [REC_W-1:0]  cur_rec;
  logic [REG_W-1:0]  reg_val;
  logic              unused_wdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
    assign set_vec[c] = {susp_set_i[c], tcmpl_set_i[c], terr_set_i[c]};
    assign set_any[c] = |set_vec[c];
    assign ch_any[c]  = |flags_q[c];
    assign rec_vec[c] = {pend_i[c], busy_i[c], ferr_i[c], flags_q[c]};
  end

  assign hit    = wr_i && (addr_i == REG_OFF);
  assign w1c    = wdata_i[B_SUSP:B_TERR];
  assign clr_wr = hit && (|w1c);
  assign sel_wr = hit && !(|w1c);
  assign unused_wdata = ^{wdata_i[15:11], wdata_i[7:5]};

  irq_lowest_enc #(.N(NUM_CH), .IW(ID_W)) u_enc (
    .req_i (ch_any),
    .idx_o (low_idx),
    .vld_o (low_vld)
  );

  irq_flag_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_en_i   (clr_wr),
    .clr_id_i   (cur_id),
    .clr_mask_i (w1c),
    .flags_o    (flags_q),
    .flags_d_o  (flags_d)
  );

  irq_ch_mux #(.N(NUM_CH), .DW(KINDS), .IW(ID_W)) u_sel_mux (
    .data_i (flags_d),
    .idx_i  (sel_q),
    .data_o (sel_nxt),
    .hit_o  (sel_hit)
  );

  // selected channel ends up empty after a clear write
  assign sel_drain = clr_wr && sel_hit && !(|sel_nxt);

  irq_id_ctrl #(.NUM_CH(NUM_CH)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_wr_i    (sel_wr),
    .sel_wdata_i (wdata_i[ID_W-1:0]),
    .sel_drain_i (sel_drain),
    .set_any_i   (set_any),
    .low_idx_i   (low_idx),
    .low_vld_i   (low_vld),
    .sel_o       (sel_q),
    .cur_id_o    (cur_id)
  );

  irq_ch_mux #(.N(NUM_CH), .DW(REC_W), .IW(ID_W)) u_cur_mux (
    .data_i (rec_vec),
    .idx_i  (cur_id),
    .data_o (cur_rec),
    .hit_o  (cur_hit)
  );

  assign any_pend = |ch_any;

  always_comb begin
    reg_val = '0;
    if (cur_hit) begin
      reg_val[B_PEND]         = cur_rec[5];
      reg_val[B_BUSY]         = cur_rec[4];
      reg_val[B_FERR]         = cur_rec[3];
      reg_val[B_SUSP:B_TERR]  = cur_rec[KINDS-1:0];
    end
    if (any_pend) reg_val[ID_W-1:0] = cur_id;
  end

  assign rdata_o = (addr_i == REG_OFF) ? reg_val : '0;
  assign irq_o   = any_pend;
endmodule

// File: rtl/irq_pend_agg_chk.sv
module irq_pend_agg_chk
  import irq_pend_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] susp_set_i,
  input logic [NUM_CH-1:0] tcmpl_set_i,
  input logic [NUM_CH-1:0] terr_set_i,
  input logic [7:0]        addr_i,
  input logic              wr_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       rdata_o,
  input logic              irq_o
);
  logic any_set;
  assign any_set = |{susp_set_i, tcmpl_set_i, terr_set_i};

  // R2
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[12:11] == 2'b0) && (rdata_o[7:5] == 3'b0));

  // R2
  a_r2_other_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != REG_OFF) |-> (rdata_o == 16'h0));

  // R4
  a_r4_idle_reads_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i == REG_OFF) && !irq_o) |-> ((rdata_o[10:8] == 3'b0) && (rdata_o[4:0] == 5'b0)));

  // R3
  a_r3_set_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_set |=> irq_o);

  // R10
  a_r10_no_rise_without_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_set |=> !$rose(irq_o));

  // R7
  a_r7_select_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == REG_OFF) && (wdata_i[10:8] == 3'b0) && !any_set) |=> $stable(irq_o));
endmodule

bind irq_pend_agg irq_pend_agg_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .susp_set_i  (susp_set_i),
  .tcmpl_set_i (tcmpl_set_i),
  .terr_set_i  (terr_set_i),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o)
);

// File: tb/sim_irq_pend_agg.sv
`timescale 1ns/1ps
module sim_irq_pend_agg;
  localparam int NCH = 6;
  localparam logic [7:0] OFF = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ss = '0, ts = '0, es = '0, sp = '0, sb = '0, sf = '0;
  logic [7:0]  addr = OFF;
  logic        wr = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_vec = 0, n_fail = 0;
  bit done = 0;

  logic [NCH-1:0] m_s = '0, m_t = '0, m_e = '0;
  bit m_sw = 0;
  logic [4:0] m_sel = '0;
  logic [31:0] lfsr = 32'h1ace_b00c;

  always #4 clk = ~clk;

  irq_pend_agg #(.NUM_CH(NCH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .susp_set_i(ss), .tcmpl_set_i(ts), .terr_set_i(es),
    .pend_i(sp), .busy_i(sb), .ferr_i(sf),
    .addr_i(addr), .wr_i(wr), .wdata_i(wd),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [4:0] m_cur();
    if (m_sw) return m_sel;
    for (int c = 0; c < NCH; c++) if (m_s[c] | m_t[c] | m_e[c]) return 5'(c);
    return 5'd0;
  endfunction

  function automatic logic [15:0] m_reg();
    logic [15:0] v = '0;
    logic [4:0] cur = m_cur();
    if (int'(cur) < NCH) begin
      v[15] = sp[cur]; v[14] = sb[cur]; v[13] = sf[cur];
      v[10] = m_s[cur]; v[9] = m_t[cur]; v[8] = m_e[cur];
    end
    if (|{m_s, m_t, m_e}) v[4:0] = cur;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nxt();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  // one cycle: drive, check pre-edge outputs, advance model
  task automatic step(input logic [NCH-1:0] s_in, t_in, e_in, input logic w,
                      input logic [7:0] a, input logic [15:0] d, input string tag);
    logic [4:0] cur;
    logic clr, selw, lower;
    logic [NCH-1:0] ns, nt, ne;
    @(negedge clk);
    ss = s_in; ts = t_in; es = e_in; wr = w; addr = a; wd = d;
    #1;
    chk(tag, rdata, (a == OFF) ? m_reg() : 16'h0);
    chk("R10", {15'd0, irq}, {15'd0, |{m_s, m_t, m_e}});
    cur  = m_cur();
    clr  = w && (a == OFF) && (d[10:8] != 3'b0);
    selw = w && (a == OFF) && (d[10:8] == 3'b0);
    ns = m_s; nt = m_t; ne = m_e;
    for (int c = 0; c < NCH; c++) begin
      if (clr && int'(cur) == c) begin
        if (d[10]) ns[c] = 1'b0;
        if (d[9])  nt[c] = 1'b0;
        if (d[8])  ne[c] = 1'b0;
      end
    end
    ns = ns | s_in; nt = nt | t_in; ne = ne | e_in;
    lower = 1'b0;
    for (int c = 0; c < NCH; c++)
      if ((s_in[c] | t_in[c] | e_in[c]) && c < int'(m_sel)) lower = 1'b1;
    if (selw) begin
      m_sw = 1; m_sel = d[4:0];
    end else if (m_sw) begin
      if (lower) m_sw = 0;
      else if (clr && int'(m_sel) < NCH && !(ns[m_sel] | nt[m_sel] | ne[m_sel])) m_sw = 0;
    end
    m_s = ns; m_t = nt; m_e = ne;
  endtask

  task automatic idle(input string tag);
    step('0, '0, '0, 1'b0, OFF, 16'h0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", rdata, 16'h0000);
    chk("R1", {15'd0, irq}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");

    // R2: other address reads zero while flags pending
    step(6'b001000, '0, '0, 1'b0, OFF, 16'h0, "R3");
    step('0, '0, '0, 1'b0, 8'h24, 16'h0, "R2");
    sp = 6'b001000; sb = 6'b000000; sf = 6'b001000;
    idle("R6");
    // R4: lower channel takes over the ID
    step('0, 6'b000010, '0, 1'b0, OFF, 16'h0, "R4");
    idle("R4");
    // R5: clear write with junk ID bits targets indicated channel
    step('0, '0, '0, 1'b1, OFF, 16'h021f, "R5");
    idle("R5");
    // R3: set and clear collide on same flag
    step('0, '0, 6'b001000, 1'b0, OFF, 16'h0, "R3");
    step(6'b001000, '0, '0, 1'b1, OFF, 16'h0400, "R3");
    idle("R3");
    // R7 and R8: select ch4, then lower channel event
    step('0, '0, 6'b010000, 1'b0, OFF, 16'h0, "R3");
    step('0, '0, '0, 1'b1, OFF, 16'h0004, "R7");
    idle("R7");
    step('0, 6'b000001, '0, 1'b0, OFF, 16'h0, "R8");
    idle("R8");
    // R8: drain selected channel
    step('0, '0, '0, 1'b1, OFF, 16'h0004, "R7");
    step('0, '0, '0, 1'b1, OFF, 16'h0100, "R8");
    idle("R8");

    // R9/R7: sweep every ID with all channels loaded
    for (int id = 0; id < 32; id++) begin
      step({NCH{1'b1}}, {NCH{1'b1}}, '0, 1'b0, OFF, 16'h0, "R3");
      sp = NCH'(lfsr); sb = NCH'(lfsr >> 8); sf = NCH'(lfsr >> 16); nxt();
      step('0, '0, '0, 1'b1, OFF, 16'(id), "R7");
      idle(id >= NCH ? "R9" : "R7");
      step('0, '0, '0, 1'b1, OFF, 16'h0700, id >= NCH ? "R9" : "R5");
      idle(id >= NCH ? "R9" : "R8");
    end

    // drain everything in automatic order
    for (int k = 0; k < 3 * NCH + 2; k++) step('0, '0, '0, 1'b1, OFF, 16'h0700, "R5");
    idle("R4");

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [NCH-1:0] rs, rt, re;
      logic w;
      logic [7:0] a;
      logic [15:0] d;
      string tg;
      nxt(); rs = NCH'(lfsr & (lfsr >> 7) & (lfsr >> 13));
      nxt(); rt = NCH'(lfsr & (lfsr >> 7) & (lfsr >> 13));
      nxt(); re = NCH'(lfsr & (lfsr >> 7) & (lfsr >> 13));
      nxt(); w = (lfsr[1:0] == 2'b00);
      a = (lfsr[4:2] == 3'b000) ? 8'h24 : OFF;
      d = lfsr[31:16];
      if (lfsr[5]) d[10:8] = 3'b000;
      nxt(); sp = NCH'(lfsr); sb = NCH'(lfsr >> 8); sf = NCH'(lfsr >> 16);
      tg = !w ? "R4" : (d[10:8] != 0 ? "R5" : "R7");
      step(rs, rt, re, w, a, d, tg);
    end
    idle("R6");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule